// File: doc/BRIEF.md
# I2C Transfer Buffer with DMA Request Events

This block sits between the software-visible side of an I2C controller and its serial engine. It holds a transmit data register and a transmit shift register, plus a receive shift register and a receive data register. A write from either the processor port or the DMA port fills the transmit data register. The serial engine then asks for that byte to be moved into the transmit shift register and shifts it out most significant bit first. Received bits enter the receive shift register one at a time. Once a whole byte has arrived, it moves into the receive data register.

Two level flags show when the transmit data register can take a new byte and when the receive data register holds an unread byte. Each time a flag is set, the block also raises a one-cycle DMA request pulse in that same cycle, so a DMA engine can serve the block with no software involved. An access from either port clears the matching flag. When a START is seen in master-transmit mode, the transmit flag is set at once, so the DMA engine gets an early request even if the slave never acknowledges its address. The one exception is 10-bit, master-transmit, repeat mode. There, every request is held back until the slave acknowledges, so that no DMA transfer starts on a spurious early event.

Top module: `i2c_xfer_buf`

## Requirements
- R1: After reset, tx_rdy, rx_rdy, rx_ovr, dma_tx_evt and dma_rx_evt are 0, and tx_bit and rx_data are all zero.
- R2: A write strobe on either port (cpu_tx_wr or dma_tx_wr) loads the transmit data register. When both strobes are high, dma_tx_data is taken. A tx_load pulse copies the transmit data register into the transmit shift register. tx_bit is bit DATA_W-1 of the shift register. tx_shift shifts it one place toward the MSB and fills 0 at bit 0. If tx_load and tx_shift are high together, the load wins.
- R3: Each rx_shift pulse enters rx_bit_in at bit 0 of the receive shift register. On the DATA_W-th shift, the completed byte (first bit received in the MSB) is offered to the receive data register. A start_det pulse resets the bit count, and any shift in that same cycle is dropped.
- R4: dma_rx_evt is high for one cycle exactly in the cycle rx_rdy becomes set by an accepted byte. dma_tx_evt is high for one cycle exactly in the cycle tx_rdy becomes set. Neither event occurs at any other time.
- R5: A read strobe on either port (cpu_rx_rd or dma_rx_rd) clears rx_rdy on the next edge, unless a byte is accepted in the same cycle. Both strobes in one cycle act as a single read.
- R6: If a byte completes while rx_rdy is 1 and no read occurs in that cycle, then rx_ovr is set, rx_data keeps its old value and no event is raised. rx_ovr stays set until the next read.
- R7: If a byte completes in the same cycle as a read, the new byte is loaded into rx_data, rx_rdy stays 1 and dma_rx_evt fires.
- R8: tx_load sets tx_rdy (with dma_tx_evt). A transmit write in the same cycle takes priority: tx_rdy ends up 0 and no event fires. A transmit write always leaves tx_rdy at 0.
- R9: start_det with master_tx=1 and not both addr10 and repeat_mode sets tx_rdy with dma_tx_evt on the next edge, whatever slave_ack does.
- R10: start_det with master_tx=1, addr10=1 and repeat_mode=1 opens a hold-off. While the hold-off is open, tx_load sets no flag, and completed receive bytes are discarded (rx_data, rx_rdy and rx_ovr are unchanged), so no event fires. The first slave_ack closes the hold-off and sets tx_rdy with dma_tx_evt (a transmit write in that cycle takes priority). A later start_det replaces the hold-off state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cpu_tx_wr | input | 1 | Processor write strobe for the transmit data register |
| cpu_tx_data | input | DATA_W | Processor write data |
| dma_tx_wr | input | 1 | DMA write strobe for the transmit data register |
| dma_tx_data | input | DATA_W | DMA write data |
| cpu_rx_rd | input | 1 | Processor read strobe for the receive data register |
| dma_rx_rd | input | 1 | DMA read strobe for the receive data register |
| tx_load | input | 1 | Serial engine request to move the data register into the shift register |
| tx_shift | input | 1 | Shift the transmit shift register by one bit |
| rx_shift | input | 1 | Sample rx_bit_in into the receive shift register |
| rx_bit_in | input | 1 | Received serial bit |
| start_det | input | 1 | START condition seen |
| master_tx | input | 1 | Controller is in master-transmit mode |
| addr10 | input | 1 | 10-bit addressing selected |
| repeat_mode | input | 1 | Repeat mode selected |
| slave_ack | input | 1 | Slave acknowledged the address |
| tx_bit | output | 1 | Current serial output bit (shift register MSB) |
| rx_data | output | DATA_W | Receive data register |
| tx_rdy | output | 1 | Transmit data register may be written |
| rx_rdy | output | 1 | Receive data register holds an unread byte |
| rx_ovr | output | 1 | A received byte was lost because rx_rdy was still set |
| dma_tx_evt | output | 1 | One-cycle DMA write request |
| dma_rx_evt | output | 1 | One-cycle DMA read request |

## Verification
Two pairs of functions can fall in the same cycle. On the receive side, a byte can complete in the cycle a read is made. On the transmit side, tx_load can coincide with a transmit write, or slave_ack with a transmit write. Directed sequences line these up on purpose: a byte is completed together with a read (R7), and tx_load is pulsed together with a write strobe (R8). The random phase keeps producing such overlaps, including reads from both ports in one cycle. Every cycle, a bench reference model that applies the requirements judges the flags, the events, rx_data and tx_bit.

// File: rtl/i2c_xb_pkg.sv
package i2c_xb_pkg;
  typedef enum logic {
    HO_OPEN_NONE = 1'b0,
    HO_WAIT_ACK  = 1'b1
  } holdoff_e;

  function automatic logic is_deferred_start(input logic addr10, input logic repeat_mode);
    return addr10 & repeat_mode;
  endfunction
endpackage

// File: rtl/xb_rst_sync.sv
module xb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/xb_evt_ctrl.sv
module xb_evt_ctrl
  import i2c_xb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_det,
  input  logic master_tx,
  input  logic addr10,
  input  logic repeat_mode,
  input  logic slave_ack,
  output logic tx_set_req,
  output logic block
);
  holdoff_e ho_q, ho_d;
  logic     qual_start, defer;

  always_comb begin
    qual_start = start_det & master_tx;
    defer      = is_deferred_start(addr10, repeat_mode);
    ho_d       = ho_q;
    if (start_det)
      ho_d = (qual_start & defer) ? HO_WAIT_ACK : HO_OPEN_NONE;
    else if (slave_ack)
      ho_d = HO_OPEN_NONE;
    tx_set_req = (qual_start & ~defer) |
                 ((ho_q == HO_WAIT_ACK) & slave_ack & ~start_det);
    block      = (ho_q == HO_WAIT_ACK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ho_q <= HO_OPEN_NONE;
    else        ho_q <= ho_d;
  end

  AST_HOLDOFF_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && master_tx && addr10 && repeat_mode) |=> block); // R10
endmodule

// File: rtl/xb_tx_path.sv
module xb_tx_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_d,
  input  logic              dma_wr,
  input  logic [DATA_W-1:0] dma_d,
  input  logic              tx_load,
  input  logic              tx_shift,
  input  logic              ext_set,
  input  logic              block,
  output logic              tx_rdy,
  output logic              tx_evt,
  output logic              tx_bit
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] dreg_q, dreg_d, sreg_q, sreg_d;
  logic              rdy_q, rdy_d, evt_q, evt_d;
  logic              wr_any, set_eff, dreg_en, sreg_en;

  always_comb begin
    wr_any  = cpu_wr | dma_wr;
    dreg_en = wr_any;
    dreg_d  = dma_wr ? dma_d : cpu_d;
    sreg_en = tx_load | tx_shift;
    sreg_d  = tx_load ? dreg_q : {sreg_q[MSB-1:0], 1'b0};
    set_eff = ((tx_load & ~block) | ext_set) & ~wr_any;
    rdy_d   = set_eff | (rdy_q & ~wr_any);
    evt_d   = set_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dreg_q <= '0;
      sreg_q <= '0;
      rdy_q  <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      if (dreg_en) dreg_q <= dreg_d;
      if (sreg_en) sreg_q <= sreg_d;
      rdy_q <= rdy_d;
      evt_q <= evt_d;
    end
  end

  assign tx_rdy = rdy_q;
  assign tx_evt = evt_q;
  assign tx_bit = sreg_q[MSB];

  AST_TX_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr || dma_wr) |=> !tx_rdy); // R8
  AST_TX_EVT_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    tx_evt |-> tx_rdy); // R4
  AST_TX_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && !(cpu_wr || dma_wr)) |=> (sreg_q == dreg_q)); // R2
endmodule

// File: rtl/xb_rx_path.sv
module xb_rx_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_rd,
  input  logic              dma_rd,
  input  logic              rx_shift,
  input  logic              rx_bit_in,
  input  logic              start_det,
  input  logic              block,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_rdy,
  output logic              rx_ovr,
  output logic              rx_evt
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sreg_q, sreg_d, dreg_q, byte_w;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              rdy_q, rdy_d, ovr_q, ovr_d, evt_q, evt_d;
  logic              rd_any, shift_ok, complete, accept, lost;

  always_comb begin
    rd_any   = cpu_rd | dma_rd;
    shift_ok = rx_shift & ~start_det;
    complete = shift_ok & (cnt_q == LAST);
    byte_w   = {sreg_q[DATA_W-2:0], rx_bit_in};
    sreg_d   = byte_w;
    if (start_det)     cnt_d = '0;
    else if (complete) cnt_d = '0;
    else if (shift_ok) cnt_d = cnt_q + 1'b1;
    else               cnt_d = cnt_q;
    accept = complete & ~block & (~rdy_q | rd_any);
    lost   = complete & ~block & rdy_q & ~rd_any;
    rdy_d  = accept | (rdy_q & ~rd_any);
    ovr_d  = lost | (ovr_q & ~rd_any);
    evt_d  = accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      dreg_q <= '0;
      cnt_q  <= '0;
      rdy_q  <= 1'b0;
      ovr_q  <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      if (shift_ok) sreg_q <= sreg_d;
      if (accept)   dreg_q <= byte_w;
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
      ovr_q <= ovr_d;
      evt_q <= evt_d;
    end
  end

  assign rx_data = dreg_q;
  assign rx_rdy  = rdy_q;
  assign rx_ovr  = ovr_q;
  assign rx_evt  = evt_q;

  AST_RX_EVT_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rx_evt |-> rx_rdy); // R4
  AST_RX_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((cpu_rd || dma_rd) && !complete) |=> !rx_rdy); // R5
  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    lost |=> (rx_ovr && $stable(rx_data) && !rx_evt)); // R6
  AST_BLOCK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (block && complete) |=> $stable(rx_data)); // R10
endmodule

// File: rtl/i2c_xfer_buf.sv
module i2c_xfer_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_tx_wr,
  input  logic [DATA_W-1:0] cpu_tx_data,
  input  logic              dma_tx_wr,
  input  logic [DATA_W-1:0] dma_tx_data,
  input  logic              cpu_rx_rd,
  input  logic              dma_rx_rd,
  input  logic              tx_load,
  input  logic              tx_shift,
  input  logic              rx_shift,
  input  logic              rx_bit_in,
  input  logic              start_det,
  input  logic              master_tx,
  input  logic              addr10,
  input  logic              repeat_mode,
  input  logic              slave_ack,
  output logic              tx_bit,
  output logic [DATA_W-1:0] rx_data,
  output logic              tx_rdy,
  output logic              rx_rdy,
  output logic              rx_ovr,
  output logic              dma_tx_evt,
  output logic              dma_rx_evt
);
  logic rst_n_i, tx_set_req, block;

  xb_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  xb_evt_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n_i), .start_det(start_det), .master_tx(master_tx),
    .addr10(addr10), .repeat_mode(repeat_mode), .slave_ack(slave_ack),
    .tx_set_req(tx_set_req), .block(block)
  );

  xb_tx_path #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n_i), .cpu_wr(cpu_tx_wr), .cpu_d(cpu_tx_data),
    .dma_wr(dma_tx_wr), .dma_d(dma_tx_data), .tx_load(tx_load),
    .tx_shift(tx_shift), .ext_set(tx_set_req), .block(block),
    .tx_rdy(tx_rdy), .tx_evt(dma_tx_evt), .tx_bit(tx_bit)
  );

  xb_rx_path #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n_i), .cpu_rd(cpu_rx_rd), .dma_rd(dma_rx_rd),
    .rx_shift(rx_shift), .rx_bit_in(rx_bit_in), .start_det(start_det),
    .block(block), .rx_data(rx_data), .rx_rdy(rx_rdy), .rx_ovr(rx_ovr),
    .rx_evt(dma_rx_evt)
  );

  AST_HOLDOFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n_i)
    (block && !slave_ack && !start_det) |=> (!dma_tx_evt && !dma_rx_evt)); // R10
  AST_PLAIN_START: assert property (@(posedge clk) disable iff (!rst_n_i)
    (start_det && master_tx && !(addr10 && repeat_mode) && !cpu_tx_wr && !dma_tx_wr)
      |=> (tx_rdy && dma_tx_evt)); // R9
endmodule

// File: tb/sim_i2c_xfer_buf.sv
module sim_i2c_xfer_buf;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_tx_wr = 0, dma_tx_wr = 0, cpu_rx_rd = 0, dma_rx_rd = 0;
  logic [W-1:0] cpu_tx_data = '0, dma_tx_data = '0;
  logic tx_load = 0, tx_shift = 0, rx_shift = 0, rx_bit_in = 0;
  logic start_det = 0, master_tx = 0, addr10 = 0, repeat_mode = 0, slave_ack = 0;
  logic tx_bit, tx_rdy, rx_rdy, rx_ovr, dma_tx_evt, dma_rx_evt;
  logic [W-1:0] rx_data;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  logic [W-1:0] m_txd, m_txs, m_rxs, m_rxd;
  int m_cnt;
  logic m_txr, m_txe, m_rxr, m_rxe, m_ovr, m_ho;

  always #4 clk = ~clk;

  i2c_xfer_buf #(.DATA_W(W)) u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_txd = '0; m_txs = '0; m_rxs = '0; m_rxd = '0; m_cnt = 0;
    m_txr = 0; m_txe = 0; m_rxr = 0; m_rxe = 0; m_ovr = 0; m_ho = 0;
  endtask

  function automatic logic model_ho_next();
    if (start_det) return master_tx & addr10 & repeat_mode;
    if (slave_ack) return 1'b0;
    return m_ho;
  endfunction

  task automatic model_step();
    logic wr, rd, sh, comp, acc, set;
    logic [W-1:0] byte_v;
    wr = cpu_tx_wr | dma_tx_wr;
    rd = cpu_rx_rd | dma_rx_rd;
    // transmit side (R2, R8, R9, R10)
    set = (tx_load & ~m_ho) | (start_det & master_tx & ~(addr10 & repeat_mode))
        | (m_ho & slave_ack & ~start_det);
    set = set & ~wr;
    if (tx_load) m_txs = m_txd;
    else if (tx_shift) m_txs = {m_txs[W-2:0], 1'b0};
    if (wr) m_txd = dma_tx_wr ? dma_tx_data : cpu_tx_data;
    m_txr = set | (m_txr & ~wr);
    m_txe = set;
    // receive side (R3, R5, R6, R7, R10)
    sh = rx_shift & ~start_det;
    comp = sh && (m_cnt == W-1);
    byte_v = {m_rxs[W-2:0], rx_bit_in};
    if (sh) m_rxs = byte_v;
    if (start_det || comp) m_cnt = 0;
    else if (sh) m_cnt++;
    acc = comp & ~m_ho & (~m_rxr | rd);
    m_ovr = (comp & ~m_ho & m_rxr & ~rd) | (m_ovr & ~rd);
    if (acc) m_rxd = byte_v;
    m_rxr = acc | (m_rxr & ~rd);
    m_rxe = acc;
    m_ho = model_ho_next();
  endtask

  task automatic compare();
    chk("R2 tx_bit", tx_bit, m_txs[W-1]);
    chk("R3 rx_data", rx_data, m_rxd);
    chk("R8 tx_rdy", tx_rdy, m_txr);
    chk("R5 rx_rdy", rx_rdy, m_rxr);
    chk("R6 rx_ovr", rx_ovr, m_ovr);
    chk("R4 dma_tx_evt", dma_tx_evt, m_txe);
    chk("R4 dma_rx_evt", dma_rx_evt, m_rxe);
  endtask

  task automatic idle();
    cpu_tx_wr = 0; dma_tx_wr = 0; cpu_rx_rd = 0; dma_rx_rd = 0;
    tx_load = 0; tx_shift = 0; rx_shift = 0; start_det = 0; slave_ack = 0;
  endtask

  // inputs are set by caller after a negedge; this advances one edge
  task automatic step();
    model_step();
    @(posedge clk); #2;
    compare();
    @(negedge clk);
    idle();
  endtask

  task automatic rx_byte(input logic [W-1:0] b, input bit rd_last);
    for (int i = W-1; i >= 0; i--) begin
      rx_shift = 1; rx_bit_in = b[i];
      if (i == 0 && rd_last) cpu_rx_rd = 1;
      step();
    end
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 flags", {tx_rdy, rx_rdy, rx_ovr, dma_tx_evt, dma_rx_evt}, 5'b0);
    chk("R1 data", {tx_bit, rx_data}, '0);
    @(negedge clk);

    // R2: write (both ports, DMA wins), load, shift out MSB first
    cpu_tx_wr = 1; dma_tx_wr = 1; cpu_tx_data = 8'h11; dma_tx_data = 8'hA5; step();
    tx_load = 1; tx_shift = 1; step();
    chk("R2 load msb", tx_bit, 1'b1);
    chk("R8 load sets", {tx_rdy, dma_tx_evt}, 2'b11);
    step();
    chk("R4 tx evt one cycle", dma_tx_evt, 1'b0);
    tx_shift = 1; step();
    chk("R2 shift bit6", tx_bit, 1'b0);

    // R8: load and write together
    tx_load = 1; cpu_tx_wr = 1; cpu_tx_data = 8'h3C; step();
    chk("R8 write wins", {tx_rdy, dma_tx_evt}, 2'b00);

    // R3 receive a byte
    rx_byte(8'hC3, 0);
    chk("R3 byte", rx_data, 8'hC3);
    chk("R4 rx evt", {rx_rdy, dma_rx_evt}, 2'b11);
    // R6 overrun
    rx_byte(8'h5A, 0);
    chk("R6 kept", {rx_ovr, rx_data}, {1'b1, 8'hC3});
    // R7 completion with read (both ports read: R5 single read)
    dma_rx_rd = 1; cpu_rx_rd = 1; step();
    chk("R5 read clears", {rx_rdy, rx_ovr}, 2'b00);
    rx_byte(8'h0F, 0);
    rx_byte(8'hE1, 1);
    chk("R7 new byte", {rx_rdy, dma_rx_evt, rx_data}, {2'b11, 8'hE1});
    dma_rx_rd = 1; step();

    // R9 plain start, no ack
    master_tx = 1; start_det = 1; step();
    chk("R9 start event", {tx_rdy, dma_tx_evt}, 2'b11);

    // R10 hold-off
    dma_tx_wr = 1; dma_tx_data = 8'h77; step();
    addr10 = 1; repeat_mode = 1; start_det = 1; step();
    chk("R10 no start event", dma_tx_evt, 1'b0);
    tx_load = 1; step();
    chk("R10 load held", {tx_rdy, dma_tx_evt}, 2'b00);
    rx_byte(8'h99, 0);
    chk("R10 rx dropped", {rx_rdy, rx_data}, {1'b0, 8'hE1});
    slave_ack = 1; step();
    chk("R10 ack releases", {tx_rdy, dma_tx_evt}, 2'b11);
    addr10 = 0; repeat_mode = 0;

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom(n == 0 ? 32'd1234 : 32'd0) ; r = $urandom;
      cpu_tx_wr = ($urandom % 8) == 0;
      dma_tx_wr = ($urandom % 8) == 0;
      cpu_tx_data = W'($urandom); dma_tx_data = W'($urandom);
      cpu_rx_rd = ($urandom % 10) == 0;
      dma_rx_rd = ($urandom % 10) == 0;
      tx_load = ($urandom % 6) == 0;
      tx_shift = r[0];
      rx_shift = r[1] | r[2];
      rx_bit_in = r[3];
      start_det = ($urandom % 40) == 0;
      slave_ack = ($urandom % 12) == 0;
      if (($urandom % 50) == 0) begin
        master_tx = r[4]; addr10 = r[5]; repeat_mode = r[6];
      end
      step();
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule